// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of every hardware thread in a multithreaded front end. Each cycle it takes block and release pulses from four downstream stages, a global context-switch stall, squash requests from the retire side and from the decoder, a per-thread flag that the reorder buffer is still flushing, and instruction-cache miss, fill and fetch-slot events that carry a thread index and, where relevant, a request tag. From these it decides, for each thread, which of eight status codes it holds. It also reports whether the fetch stage as a whole has useful work.

A squash redirects the thread. The block registers the new program counter and the address of the next sequential instruction (four bytes on) for the fetch unit to load. Squashes outrank stalls. A thread that waits on a cache miss cannot be pulled into the blocked state by a stall. A fill that arrives while a stall is pending sends the thread straight to blocked, not to the resume state. Thread and request tags are checked, so stale fills and out-of-range thread indices have no effect.

All status changes take effect at the clock edge that samples the causing inputs. The redirect outputs are registered and are valid for the single cycle after that edge.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread reads Running, and `redir_vld` is low. Status codes are 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 MissWait, 5 MissDone, 6 TrapWait and 7 QuiesceWait. Thread t occupies bits [3t+2:3t] of `thr_state`.
- R2: Each thread keeps one sticky stall flag per downstream source (decode, rename, execute, commit). A block pulse sets the flag and a release pulse clears it, and a release touches only its own source's flag. A block and a release from the same source for the same thread never arrive together.
- R3: A thread counts as stalled while `ctx_switch` is high or any of its four flags is set. A stalled thread that is not in MissWait moves to Blocked. A thread in Blocked or Squashing that is neither stalled nor squashed returns to Running.
- R4: A commit squash for a thread wins over every other event. The thread moves to Squashing. The next cycle `redir_vld` is high, `redir_tid` names the thread, `redir_pc` holds the squash PC and `redir_npc` holds that PC plus 4.
- R5: While `rob_sq[t]` is high, thread t is in Squashing at the following edge.
- R6: A decode squash acts like a commit squash, including the redirect. It is ignored when the thread is already in Squashing, when `rob_sq` is set for that thread, or when a commit squash for any in-range thread arrives in the same cycle.
- R7: A miss report for a thread in Running, with no higher-priority event, moves it to MissWait and records the request tag. While in MissWait, stalls do not move the thread. A fill with the wrong thread or the wrong tag is ignored.
- R8: An accepted fill moves the thread to Blocked if it is stalled and to MissDone otherwise. A fetch slot granted to a thread in MissDone moves it to Running.
- R9: `stage_active` is high exactly when some thread enabled in `thr_en` is in Running, Squashing or MissDone.
- R10: A park request for a thread in Running moves it to TrapWait (kind 0), QuiesceWait (kind 1) or Idle (kind 2); kind 3 is ignored. A parked thread stays parked until a squash arrives or a stall occurs.
- R11: Any event whose thread index is not below `NUM_THR` has no effect on status or redirect.
- R12: A squash cancels an outstanding miss, so a later fill carrying the old tag leaves the thread unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | NUM_THR | Threads that count toward stage activity |
| ctx_switch | input | 1 | Context switch in progress; stalls all threads |
| dec_blk | input | NUM_THR | Decode block pulse per thread |
| dec_unblk | input | NUM_THR | Decode release pulse per thread |
| ren_blk | input | NUM_THR | Rename block pulse per thread |
| ren_unblk | input | NUM_THR | Rename release pulse per thread |
| exe_blk | input | NUM_THR | Execute block pulse per thread |
| exe_unblk | input | NUM_THR | Execute release pulse per thread |
| cmt_blk | input | NUM_THR | Commit block pulse per thread |
| cmt_unblk | input | NUM_THR | Commit release pulse per thread |
| cmt_sq_vld | input | 1 | Commit squash request |
| cmt_sq_tid | input | TID_W | Thread of the commit squash |
| cmt_sq_pc | input | PC_W | Redirect PC of the commit squash |
| rob_sq | input | NUM_THR | Reorder buffer still flushing the thread |
| dec_sq_vld | input | 1 | Decode squash request |
| dec_sq_tid | input | TID_W | Thread of the decode squash |
| dec_sq_pc | input | PC_W | Redirect PC of the decode squash |
| miss_vld | input | 1 | Cache miss report |
| miss_tid | input | TID_W | Thread of the miss |
| miss_req | input | REQ_W | Request tag of the miss |
| fill_vld | input | 1 | Cache fill completion |
| fill_tid | input | TID_W | Thread of the fill |
| fill_req | input | REQ_W | Request tag of the fill |
| fetch_vld | input | 1 | Fetch slot granted |
| fetch_tid | input | TID_W | Thread given the fetch slot |
| park_vld | input | 1 | Park request |
| park_tid | input | TID_W | Thread to park |
| park_kind | input | 2 | 0 trap, 1 quiesce, 2 idle, 3 ignored |
| thr_state | output | 3*NUM_THR | Packed per-thread status codes |
| stage_active | output | 1 | Stage has a thread able to make progress |
| redir_vld | output | 1 | Redirect valid this cycle |
| redir_tid | output | TID_W | Thread being redirected |
| redir_pc | output | PC_W | New fetch PC |
| redir_npc | output | PC_W | New fetch PC plus 4 |

## Verification
Assertions check on every cycle the following event orderings: a commit squash or a flushing reorder buffer lands in Squashing, MissWait survives every non-squash, non-fill cycle, a commit squash produces a matching redirect, a granted slot in MissDone resumes, and no source blocks and releases a thread at once. Other behaviours depend on multi-cycle histories, and only the bench scenarios can show them. These are the sticky flags held across idle cycles, independent release per source, a stall re-blocking a thread after a squash, a stale tag or thread being rejected after a squash, the parked states, the stage-active flag under thread masks, and out-of-range indices.

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl #(
  parameter int NUM_THR = 3,
  parameter int PC_W    = 32,
  parameter int REQ_W   = 4,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_THR-1:0]   thr_en,
  input  logic                 ctx_switch,
  input  logic [NUM_THR-1:0]   dec_blk,
  input  logic [NUM_THR-1:0]   dec_unblk,
  input  logic [NUM_THR-1:0]   ren_blk,
  input  logic [NUM_THR-1:0]   ren_unblk,
  input  logic [NUM_THR-1:0]   exe_blk,
  input  logic [NUM_THR-1:0]   exe_unblk,
  input  logic [NUM_THR-1:0]   cmt_blk,
  input  logic [NUM_THR-1:0]   cmt_unblk,
  input  logic                 cmt_sq_vld,
  input  logic [TID_W-1:0]     cmt_sq_tid,
  input  logic [PC_W-1:0]      cmt_sq_pc,
  input  logic [NUM_THR-1:0]   rob_sq,
  input  logic                 dec_sq_vld,
  input  logic [TID_W-1:0]     dec_sq_tid,
  input  logic [PC_W-1:0]      dec_sq_pc,
  input  logic                 miss_vld,
  input  logic [TID_W-1:0]     miss_tid,
  input  logic [REQ_W-1:0]     miss_req,
  input  logic                 fill_vld,
  input  logic [TID_W-1:0]     fill_tid,
  input  logic [REQ_W-1:0]     fill_req,
  input  logic                 fetch_vld,
  input  logic [TID_W-1:0]     fetch_tid,
  input  logic                 park_vld,
  input  logic [TID_W-1:0]     park_tid,
  input  logic [1:0]           park_kind,
  output logic [3*NUM_THR-1:0] thr_state,
  output logic                 stage_active,
  output logic                 redir_vld,
  output logic [TID_W-1:0]     redir_tid,
  output logic [PC_W-1:0]      redir_pc,
  output logic [PC_W-1:0]      redir_npc
);

  localparam logic [2:0] S_RUN  = 3'd0;
  localparam logic [2:0] S_IDLE = 3'd1;
  localparam logic [2:0] S_SQ   = 3'd2;
  localparam logic [2:0] S_BLK  = 3'd3;
  localparam logic [2:0] S_MISS = 3'd4;
  localparam logic [2:0] S_MDON = 3'd5;
  localparam logic [2:0] S_TRAP = 3'd6;
  localparam logic [2:0] S_QUI  = 3'd7;

  logic [NUM_THR-1:0] f_dec, f_ren, f_exe, f_cmt;
  logic [NUM_THR-1:0] f_dec_d, f_ren_d, f_exe_d, f_cmt_d;
  logic [NUM_THR-1:0] stalled_d;
  logic [NUM_THR-1:0] cmt_hit, dec_hit, fill_ok, miss_hit, fetch_hit, park_hit;
  logic [2:0]         st_q [NUM_THR];
  logic [2:0]         st_d [NUM_THR];
  logic [REQ_W-1:0]   req_q [NUM_THR];
  logic               cmt_ok;

  assign f_dec_d   = (f_dec | dec_blk) & ~dec_unblk;
  assign f_ren_d   = (f_ren | ren_blk) & ~ren_unblk;
  assign f_exe_d   = (f_exe | exe_blk) & ~exe_unblk;
  assign f_cmt_d   = (f_cmt | cmt_blk) & ~cmt_unblk;
  assign stalled_d = f_dec_d | f_ren_d | f_exe_d | f_cmt_d | {NUM_THR{ctx_switch}};
  assign cmt_ok    = cmt_sq_vld && (int'(cmt_sq_tid) < NUM_THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_dec <= '0;
      f_ren <= '0;
      f_exe <= '0;
      f_cmt <= '0;
    end else begin
      f_dec <= f_dec_d;
      f_ren <= f_ren_d;
      f_exe <= f_exe_d;
      f_cmt <= f_cmt_d;
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign cmt_hit[t]   = cmt_sq_vld && (cmt_sq_tid == TID_W'(t));
    assign dec_hit[t]   = dec_sq_vld && (dec_sq_tid == TID_W'(t)) && !cmt_ok &&
                          !rob_sq[t] && (st_q[t] != S_SQ);
    assign fill_ok[t]   = fill_vld && (fill_tid == TID_W'(t)) && (st_q[t] == S_MISS) &&
                          (fill_req == req_q[t]);
    assign miss_hit[t]  = miss_vld && (miss_tid == TID_W'(t));
    assign fetch_hit[t] = fetch_vld && (fetch_tid == TID_W'(t));
    assign park_hit[t]  = park_vld && (park_tid == TID_W'(t));
    assign thr_state[3*t +: 3] = st_q[t];

    always_comb begin
      st_d[t] = st_q[t];
      if (cmt_hit[t] || rob_sq[t] || dec_hit[t])
        st_d[t] = S_SQ;
      else if (fill_ok[t])
        st_d[t] = stalled_d[t] ? S_BLK : S_MDON;
      else if (stalled_d[t] && st_q[t] != S_MISS)
        st_d[t] = S_BLK;
      else if (st_q[t] == S_BLK || st_q[t] == S_SQ)
        st_d[t] = S_RUN;
      else if (st_q[t] == S_RUN && miss_hit[t])
        st_d[t] = S_MISS;
      else if (st_q[t] == S_MDON && fetch_hit[t])
        st_d[t] = S_RUN;
      else if (st_q[t] == S_RUN && park_hit[t]) begin
        case (park_kind)
          2'd0:    st_d[t] = S_TRAP;
          2'd1:    st_d[t] = S_QUI;
          2'd2:    st_d[t] = S_IDLE;
          default: st_d[t] = S_RUN;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[t]  <= S_RUN;
        req_q[t] <= '0;
      end else begin
        st_q[t] <= st_d[t];
        if (st_d[t] == S_MISS && st_q[t] != S_MISS) req_q[t] <= miss_req;
      end
    end

    p_cmt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_hit[t] |=> st_q[t] == S_SQ);

    p_rob_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rob_sq[t] |=> st_q[t] == S_SQ);

    p_miss_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[t] == S_MISS && !cmt_hit[t] && !rob_sq[t] && !dec_hit[t] && !fill_vld)
      |=> st_q[t] == S_MISS);

    p_mdon_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[t] == S_MDON && fetch_hit[t] && !cmt_hit[t] && !rob_sq[t] && !dec_hit[t] &&
       !stalled_d[t]) |=> st_q[t] == S_RUN);
  end

  always_comb begin
    stage_active = 1'b0;
    for (int t = 0; t < NUM_THR; t++)
      if (thr_en[t] && (st_q[t] == S_RUN || st_q[t] == S_SQ || st_q[t] == S_MDON))
        stage_active = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld <= 1'b0;
      redir_tid <= '0;
      redir_pc  <= '0;
      redir_npc <= '0;
    end else if (cmt_ok) begin
      redir_vld <= 1'b1;
      redir_tid <= cmt_sq_tid;
      redir_pc  <= cmt_sq_pc;
      redir_npc <= cmt_sq_pc + PC_W'(4);
    end else if (|dec_hit) begin
      redir_vld <= 1'b1;
      redir_tid <= dec_sq_tid;
      redir_pc  <= dec_sq_pc;
      redir_npc <= dec_sq_pc + PC_W'(4);
    end else begin
      redir_vld <= 1'b0;
    end
  end

  p_redir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_ok |=> redir_vld && redir_pc == $past(cmt_sq_pc) &&
               redir_npc == $past(cmt_sq_pc) + PC_W'(4));

  p_no_blk_rel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_blk & dec_unblk) | (ren_blk & ren_unblk) | (exe_blk & exe_unblk) |
     (cmt_blk & cmt_unblk)) == '0);

endmodule

// File: tb/test_fetch_status_ctl.sv
module test_fetch_status_ctl;
  localparam int N = 3;
  localparam int TW = 2;
  localparam int PW = 32;
  localparam int RW = 4;
  localparam int RUN = 0, IDLE = 1, SQ = 2, BLK = 3, MISS = 4, MDON = 5, TRAP = 6, QUI = 7;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] thr_en = '1;
  logic ctx_switch;
  logic [N-1:0] dec_blk, dec_unblk, ren_blk, ren_unblk, exe_blk, exe_unblk, cmt_blk, cmt_unblk;
  logic cmt_sq_vld; logic [TW-1:0] cmt_sq_tid; logic [PW-1:0] cmt_sq_pc;
  logic [N-1:0] rob_sq;
  logic dec_sq_vld; logic [TW-1:0] dec_sq_tid; logic [PW-1:0] dec_sq_pc;
  logic miss_vld; logic [TW-1:0] miss_tid; logic [RW-1:0] miss_req;
  logic fill_vld; logic [TW-1:0] fill_tid; logic [RW-1:0] fill_req;
  logic fetch_vld; logic [TW-1:0] fetch_tid;
  logic park_vld; logic [TW-1:0] park_tid; logic [1:0] park_kind;
  logic [3*N-1:0] thr_state;
  logic stage_active, redir_vld;
  logic [TW-1:0] redir_tid;
  logic [PW-1:0] redir_pc, redir_npc;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fetch_status_ctl #(.NUM_THR(N), .PC_W(PW), .REQ_W(RW)) i_fetch_status_ctl (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .ctx_switch(ctx_switch),
    .dec_blk(dec_blk), .dec_unblk(dec_unblk), .ren_blk(ren_blk), .ren_unblk(ren_unblk),
    .exe_blk(exe_blk), .exe_unblk(exe_unblk), .cmt_blk(cmt_blk), .cmt_unblk(cmt_unblk),
    .cmt_sq_vld(cmt_sq_vld), .cmt_sq_tid(cmt_sq_tid), .cmt_sq_pc(cmt_sq_pc), .rob_sq(rob_sq),
    .dec_sq_vld(dec_sq_vld), .dec_sq_tid(dec_sq_tid), .dec_sq_pc(dec_sq_pc),
    .miss_vld(miss_vld), .miss_tid(miss_tid), .miss_req(miss_req),
    .fill_vld(fill_vld), .fill_tid(fill_tid), .fill_req(fill_req),
    .fetch_vld(fetch_vld), .fetch_tid(fetch_tid),
    .park_vld(park_vld), .park_tid(park_tid), .park_kind(park_kind),
    .thr_state(thr_state), .stage_active(stage_active), .redir_vld(redir_vld),
    .redir_tid(redir_tid), .redir_pc(redir_pc), .redir_npc(redir_npc));

  task automatic clr();
    ctx_switch = 0; rob_sq = '0;
    dec_blk = '0; dec_unblk = '0; ren_blk = '0; ren_unblk = '0;
    exe_blk = '0; exe_unblk = '0; cmt_blk = '0; cmt_unblk = '0;
    cmt_sq_vld = 0; cmt_sq_tid = '0; cmt_sq_pc = '0;
    dec_sq_vld = 0; dec_sq_tid = '0; dec_sq_pc = '0;
    miss_vld = 0; miss_tid = '0; miss_req = '0;
    fill_vld = 0; fill_tid = '0; fill_req = '0;
    fetch_vld = 0; fetch_tid = '0;
    park_vld = 0; park_tid = '0; park_kind = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic step();
    tick(); clr();
  endtask

  task automatic chk(string r, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic chk_st(string r, int t, int exp);
    chk(r, longint'(thr_state[3*t +: 3]), longint'(exp));
  endtask

  task automatic chk_all(string r, int s0, int s1, int s2);
    chk_st(r, 0, s0); chk_st(r, 1, s1); chk_st(r, 2, s2);
  endtask

  task automatic set_src(int src, int t, logic b, logic u);
    case (src)
      0: begin dec_blk[t] = b; dec_unblk[t] = u; end
      1: begin ren_blk[t] = b; ren_unblk[t] = u; end
      2: begin exe_blk[t] = b; exe_unblk[t] = u; end
      default: begin cmt_blk[t] = b; cmt_unblk[t] = u; end
    endcase
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R1 reset state
    chk_all("R1 reset", RUN, RUN, RUN);
    chk("R1 redir low", redir_vld, 0);
    chk("R9 active after reset", stage_active, 1);

    // R2 R3 sweep every source and thread
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < N; t++) begin
        set_src(s, t, 1, 0); step();
        for (int k = 0; k < N; k++) chk_st("R3 block", k, (k == t) ? BLK : RUN);
        step();
        chk_st("R2 sticky", t, BLK);
        set_src(s, t, 0, 1); step();
        chk_st("R2 release", t, RUN);
      end
    end

    // R2 release touches only its own source
    dec_blk[0] = 1; ren_blk[0] = 1; step();
    dec_unblk[0] = 1; step();
    chk_st("R2 other source held", 0, BLK);
    ren_unblk[0] = 1; step();
    chk_st("R2 both released", 0, RUN);

    // R3 context switch
    ctx_switch = 1; step();
    chk_all("R3 ctx stall", BLK, BLK, BLK);
    step();
    chk_all("R3 ctx end", RUN, RUN, RUN);

    // R4 commit squash over a stall
    dec_blk[1] = 1; step();
    cmt_sq_vld = 1; cmt_sq_tid = 1; cmt_sq_pc = 32'h100; step();
    chk_st("R4 squash over stall", 1, SQ);
    chk("R4 redir vld", redir_vld, 1);
    chk("R4 redir tid", redir_tid, 1);
    chk("R4 redir pc", redir_pc, 32'h100);
    chk("R4 redir npc", redir_npc, 32'h104);
    step();
    chk_st("R3 reblock after squash", 1, BLK);
    chk("R4 redir one cycle", redir_vld, 0);
    dec_unblk[1] = 1; step();
    chk_st("R3 resume", 1, RUN);

    // R5 reorder buffer flushing
    for (int k = 0; k < 3; k++) begin
      rob_sq[2] = 1; step();
      chk_st("R5 rob hold", 2, SQ);
    end
    step();
    chk_st("R5 rob end", 2, RUN);

    // R6 decode squash
    dec_sq_vld = 1; dec_sq_tid = 0; dec_sq_pc = 32'h200; step();
    chk_st("R6 dec squash", 0, SQ);
    chk("R6 dec redir pc", redir_pc, 32'h200);
    chk("R6 dec redir npc", redir_npc, 32'h204);
    step();
    chk_st("R6 dec done", 0, RUN);
    rob_sq[0] = 1; step();
    dec_sq_vld = 1; dec_sq_tid = 0; dec_sq_pc = 32'h300; step();
    chk("R6 ignored while squashing", redir_vld, 0);
    chk_st("R6 ignored state", 0, RUN);
    cmt_sq_vld = 1; cmt_sq_tid = 1; cmt_sq_pc = 32'h400;
    dec_sq_vld = 1; dec_sq_tid = 2; dec_sq_pc = 32'h500; step();
    chk_all("R6 commit same cycle", RUN, SQ, RUN);
    chk("R6 commit wins redir", redir_pc, 32'h400);
    chk("R6 commit wins tid", redir_tid, 1);
    step();

    // R7 R8 miss handling
    miss_vld = 1; miss_tid = 1; miss_req = 5; step();
    chk_st("R7 miss entry", 1, MISS);
    ren_blk[1] = 1; step();
    chk_st("R7 miss immune to stall", 1, MISS);
    fill_vld = 1; fill_tid = 1; fill_req = 6; step();
    chk_st("R7 wrong tag", 1, MISS);
    fill_vld = 1; fill_tid = 0; fill_req = 5; step();
    chk_st("R7 wrong thread", 1, MISS);
    chk_st("R7 wrong thread other", 0, RUN);
    fill_vld = 1; fill_tid = 1; fill_req = 5; step();
    chk_st("R8 fill while stalled", 1, BLK);
    ren_unblk[1] = 1; step();
    chk_st("R8 release", 1, RUN);
    thr_en = 3'b010;
    miss_vld = 1; miss_tid = 1; miss_req = 3; step();
    chk("R9 inactive on miss", stage_active, 0);
    fill_vld = 1; fill_tid = 1; fill_req = 3; step();
    chk_st("R8 fill resume state", 1, MDON);
    chk("R9 active on fill", stage_active, 1);
    step();
    chk_st("R8 waits for slot", 1, MDON);
    fetch_vld = 1; fetch_tid = 1; step();
    chk_st("R8 slot resumes", 1, RUN);
    thr_en = '1;

    // R12 squash cancels miss
    miss_vld = 1; miss_tid = 0; miss_req = 2; step();
    chk_st("R12 miss", 0, MISS);
    cmt_sq_vld = 1; cmt_sq_tid = 0; cmt_sq_pc = 32'h600; step();
    chk_st("R12 squash", 0, SQ);
    step();
    fill_vld = 1; fill_tid = 0; fill_req = 2; step();
    chk_st("R12 stale fill", 0, RUN);

    // R10 park states
    for (int k = 0; k < 3; k++) begin
      park_vld = 1; park_tid = 2; park_kind = 2'(k); step();
      chk_st("R10 park", 2, (k == 0) ? TRAP : (k == 1) ? QUI : IDLE);
      step();
      chk_st("R10 park held", 2, (k == 0) ? TRAP : (k == 1) ? QUI : IDLE);
      thr_en = 3'b100; #1;
      chk("R9 parked inactive", stage_active, 0);
      cmt_sq_vld = 1; cmt_sq_tid = 2; cmt_sq_pc = 32'h700; step();
      chk_st("R10 squash unparks", 2, SQ);
      chk("R9 squashing active", stage_active, 1);
      thr_en = '1;
      step();
      chk_st("R10 back", 2, RUN);
    end
    park_vld = 1; park_tid = 0; park_kind = 2'd3; step();
    chk_st("R10 kind 3 ignored", 0, RUN);

    // R11 out of range index
    cmt_sq_vld = 1; cmt_sq_tid = 3; cmt_sq_pc = 32'h800; step();
    chk("R11 cmt redir", redir_vld, 0);
    chk_all("R11 cmt state", RUN, RUN, RUN);
    dec_sq_vld = 1; dec_sq_tid = 3; dec_sq_pc = 32'h900; step();
    chk("R11 dec redir", redir_vld, 0);
    miss_vld = 1; miss_tid = 3; miss_req = 1; step();
    chk_all("R11 miss", RUN, RUN, RUN);
    park_vld = 1; park_tid = 3; park_kind = 0; step();
    chk_all("R11 park", RUN, RUN, RUN);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule